// File: doc/BRIEF.md
# Byte-Coded Dual-Stack Processor Core

This core is a small stack machine. It fetches 8-bit opcodes from a byte-wide memory and keeps its working values on a data stack. A second stack holds return addresses and saved flags. Beside the two stacks it holds a 16-bit address register A, a program counter and a two-bit flag register. The flag register holds zero in bit 0 and carry/borrow in bit 1. Each instruction may be followed by one or two immediate bytes, stored low byte first. Bit 7 of every opcode is a suffix: when it is set, the data-stack top moves into A after the main operation.

A subroutine call is built from two instructions. The first pushes a PC-relative return address onto the return stack. The second loads the target into PC. A return pops the return stack into PC. Program and data share one synchronous memory port with one cycle of read latency. A halt opcode stops the sequencer. Observation ports expose the architectural state at instruction boundaries.

Top module: `stk_core`

## Requirements
- R1: Reset clears PC, A, the flags and both stacks, so every stack slot and both tops read 0. The first instruction is fetched from address 0.
- R2: An instruction takes 3 cycles, plus 1 per operand byte, plus 1 for a byte load, plus 1 when the suffix bit is set. `at_boundary` is high in the first cycle of each instruction. Opcodes not listed here (for example 0x7F) only consume their cycles.
- R3: 0x01 pushes the next byte zero-extended. 0x02 pushes the next two bytes as a word, low byte first.
- R4: 0x03 pushes the byte at address A, zero-extended. 0x04 writes the low byte of the top to address A and pops.
- R5: 0x05 duplicates the top, 0x06 pushes a copy of the second entry, and 0x07 discards the top.
- R6: 0x08 replaces the top two entries with their 16-bit sum and sets carry to the carry out. 0x09 decrements the top and sets carry when the top was 0. Both set zero when the result is 0. No other arithmetic changes the flags.
- R7: 0x0C, 0x0D, 0x0E and 0x0F branch on zero set, zero clear, carry set and carry clear respectively. The target is the address after the instruction plus the signed displacement byte.
- R8: 0x0A loads PC with a 16-bit word. 0x0B adds a signed byte to the address after it, so a displacement of 1 skips one byte. 0x12 pops the data stack into PC.
- R9: 0x10 pushes onto the return stack the address after it plus a signed byte. 0x11 pops the return stack into PC.
- R10: Flags travel as the value {14'b0, carry, zero}. 0x13 pushes them to the data stack and 0x14 pops them from it. 0x15 pushes them to the return stack and 0x16 pops them from it.
- R11: 0x17 moves the data top onto the return stack. 0x18 moves the return top onto the data stack.
- R12: With bit 7 set, after the operation of the low seven bits, A takes the data top and the data stack pops.
- R13: Each stack has a top plus a 16-slot ring below it. Pushing beyond that overwrites the oldest slot, and popping past the bottom wraps the same way, without any signal.
- R14: 0x00 (with or without the suffix) stops execution. `halted` stays high and no memory write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Byte address for the read or write |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| at_boundary | output | 1 | First cycle of an instruction |
| halted | output | 1 | Sequencer stopped |
| dbg_pc | output | 16 | Program counter |
| dbg_a | output | 16 | Address register |
| dbg_flags | output | 2 | {carry, zero} |
| dbg_tos | output | 16 | Data-stack top |
| dbg_nos | output | 16 | Data-stack second entry |
| dbg_rtos | output | 16 | Return-stack top |
| dbg_rnos | output | 16 | Return-stack second entry |

## Verification
A wrong stack pointer or top register appears in the stack observation ports at the next instruction boundary. Later it also reaches PC, A and memory contents through ops such as return, pop-into-A and stores. A sequencer that spends one cycle too many or too few is caught by the boundary spacing in the same instruction. A misplaced PC or wrong flags show at the next boundary as a mismatched PC, because branches and relative loads depend on both. Memory contents are compared once at the end of each program run.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int FW = 2;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_OP1, S_OP2, S_EXEC, S_LOADW, S_POPA, S_HALT
    } state_e;

    typedef enum logic [2:0] {
        SK_HOLD, SK_PUSH, SK_POP, SK_POPSET, SK_SET
    } stk_op_e;

    localparam logic [6:0] OP_HALT    = 7'h00;
    localparam logic [6:0] OP_PUSHB   = 7'h01;
    localparam logic [6:0] OP_PUSHW   = 7'h02;
    localparam logic [6:0] OP_LDB     = 7'h03;
    localparam logic [6:0] OP_STB     = 7'h04;
    localparam logic [6:0] OP_DUP     = 7'h05;
    localparam logic [6:0] OP_OVER    = 7'h06;
    localparam logic [6:0] OP_DROP    = 7'h07;
    localparam logic [6:0] OP_ADD     = 7'h08;
    localparam logic [6:0] OP_DEC     = 7'h09;
    localparam logic [6:0] OP_LDPC    = 7'h0A;
    localparam logic [6:0] OP_LDPCR   = 7'h0B;
    localparam logic [6:0] OP_BZ      = 7'h0C;
    localparam logic [6:0] OP_BNZ     = 7'h0D;
    localparam logic [6:0] OP_BC      = 7'h0E;
    localparam logic [6:0] OP_BNC     = 7'h0F;
    localparam logic [6:0] OP_RPUSHPC = 7'h10;
    localparam logic [6:0] OP_RPOPPC  = 7'h11;
    localparam logic [6:0] OP_POPPC   = 7'h12;
    localparam logic [6:0] OP_PUSHS   = 7'h13;
    localparam logic [6:0] OP_POPS    = 7'h14;
    localparam logic [6:0] OP_RPUSHS  = 7'h15;
    localparam logic [6:0] OP_RPOPS   = 7'h16;
    localparam logic [6:0] OP_TOR     = 7'h17;
    localparam logic [6:0] OP_FROMR   = 7'h18;

    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   a;
        logic [FW-1:0]   flg;
        logic [7:0]      ir;
        logic [DW-1:0]   imm;
    } core_regs_t;

    function automatic logic [1:0] operand_bytes(input logic [6:0] op);
        case (op)
            OP_PUSHB, OP_LDPCR, OP_RPUSHPC,
            OP_BZ, OP_BNZ, OP_BC, OP_BNC:   return 2'd1;
            OP_PUSHW, OP_LDPC:              return 2'd2;
            default:                        return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/stk_lifo.sv
module stk_lifo
    import stk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stk_op_e      op,
    input  logic [W-1:0] din,
    output logic [W-1:0] tos,
    output logic [W-1:0] nos
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] ONE = PW'(1);

    typedef struct packed {
        logic [PW-1:0] sp;
        logic [W-1:0]  top;
    } lifo_t;

    lifo_t          r_q, r_d;
    logic [W-1:0]   slot_q [DEPTH];
    logic           wr_en;
    logic [PW-1:0]  wr_idx;

    always_comb begin
        r_d    = r_q;
        wr_en  = 1'b0;
        wr_idx = r_q.sp + ONE;
        unique case (op)
            SK_PUSH: begin
                wr_en   = 1'b1;
                r_d.sp  = r_q.sp + ONE;
                r_d.top = din;
            end
            SK_POP: begin
                r_d.top = slot_q[r_q.sp];
                r_d.sp  = r_q.sp - ONE;
            end
            SK_POPSET: begin
                r_d.top = din;
                r_d.sp  = r_q.sp - ONE;
            end
            SK_SET:  r_d.top = din;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              slot_q[i] <= '0;
            else if (wr_en && wr_idx == PW'(i))      slot_q[i] <= r_q.top;
        end
    end

    assign tos = r_q.top;
    assign nos = slot_q[r_q.sp];

    AST_PUSH_SAVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_PUSH) |=> (nos == $past(tos) && tos == $past(din))); // R13
    AST_POP_EXPOSES_NOS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_POP) |=> (tos == $past(nos))); // R13

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
(
    input  logic [DW-1:0] top,
    input  logic [DW-1:0] under,
    input  logic          do_dec,
    output logic [DW-1:0] res,
    output logic          carry,
    output logic          zero
);
    logic [DW:0] wide;

    always_comb begin
        if (do_dec) wide = {1'b0, top} - {{DW{1'b0}}, 1'b1};
        else        wide = {1'b0, under} + {1'b0, top};
        res   = wide[DW-1:0];
        carry = wide[DW];
        zero  = (wide[DW-1:0] == '0);
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [15:0]   mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          at_boundary,
    output logic          halted,
    output logic [15:0]   dbg_pc,
    output logic [15:0]   dbg_a,
    output logic [1:0]    dbg_flags,
    output logic [15:0]   dbg_tos,
    output logic [15:0]   dbg_nos,
    output logic [15:0]   dbg_rtos,
    output logic [15:0]   dbg_rnos
);
    core_regs_t     cq, cd;
    stk_op_e        ds_op, rs_op;
    logic [DW-1:0]  ds_din, rs_din, ds_tos, ds_nos, rs_tos, rs_nos;
    logic [DW-1:0]  alu_res;
    logic           alu_c, alu_z;
    logic [6:0]     op7;
    logic [AW-1:0]  pc_rel;
    logic           take;
    state_e         after_exec;
    logic [AW-1:0]  bus_addr;
    logic           bus_we;

    stk_lifo #(.DEPTH(STACK_DEPTH), .W(DW)) u_dstk (
        .clk(clk), .rst_n(rst_n), .op(ds_op), .din(ds_din), .tos(ds_tos), .nos(ds_nos));

    stk_lifo #(.DEPTH(STACK_DEPTH), .W(DW)) u_rstk (
        .clk(clk), .rst_n(rst_n), .op(rs_op), .din(rs_din), .tos(rs_tos), .nos(rs_nos));

    stk_alu u_alu (
        .top(ds_tos), .under(ds_nos), .do_dec(op7 == OP_DEC),
        .res(alu_res), .carry(alu_c), .zero(alu_z));

    assign op7        = cq.ir[6:0];
    assign pc_rel     = cq.pc + {{(AW-8){cq.imm[7]}}, cq.imm[7:0]};
    assign take       = (op7[1] ? cq.flg[1] : cq.flg[0]) ^ op7[0];
    assign after_exec = cq.ir[7] ? S_POPA : S_FETCH;

    always_comb begin
        cd       = cq;
        ds_op    = SK_HOLD;
        ds_din   = ds_tos;
        rs_op    = SK_HOLD;
        rs_din   = ds_tos;
        bus_addr = cq.pc;
        bus_we   = 1'b0;
        unique case (cq.st)
            S_FETCH: begin
                cd.pc = cq.pc + 16'd1;
                cd.st = S_DECODE;
            end
            S_DECODE: begin
                cd.ir  = mem_rdata;
                cd.imm = '0;
                if (operand_bytes(mem_rdata[6:0]) != 2'd0) begin
                    cd.pc = cq.pc + 16'd1;
                    cd.st = S_OP1;
                end else begin
                    cd.st = S_EXEC;
                end
            end
            S_OP1: begin
                cd.imm[7:0] = mem_rdata;
                if (operand_bytes(op7) == 2'd2) begin
                    cd.pc = cq.pc + 16'd1;
                    cd.st = S_OP2;
                end else begin
                    cd.st = S_EXEC;
                end
            end
            S_OP2: begin
                cd.imm[15:8] = mem_rdata;
                cd.st        = S_EXEC;
            end
            S_EXEC: begin
                bus_addr = cq.a;
                cd.st    = after_exec;
                case (op7)
                    OP_HALT:    cd.st = S_HALT;
                    OP_PUSHB:   begin ds_op = SK_PUSH; ds_din = {8'h00, cq.imm[7:0]}; end
                    OP_PUSHW:   begin ds_op = SK_PUSH; ds_din = cq.imm; end
                    OP_LDB:     cd.st = S_LOADW;
                    OP_STB:     begin bus_we = 1'b1; ds_op = SK_POP; end
                    OP_DUP:     begin ds_op = SK_PUSH; ds_din = ds_tos; end
                    OP_OVER:    begin ds_op = SK_PUSH; ds_din = ds_nos; end
                    OP_DROP:    ds_op = SK_POP;
                    OP_ADD:     begin ds_op = SK_POPSET; ds_din = alu_res; cd.flg = {alu_c, alu_z}; end
                    OP_DEC:     begin ds_op = SK_SET;    ds_din = alu_res; cd.flg = {alu_c, alu_z}; end
                    OP_LDPC:    cd.pc = cq.imm;
                    OP_LDPCR:   cd.pc = pc_rel;
                    OP_BZ, OP_BNZ, OP_BC, OP_BNC:
                                if (take) cd.pc = pc_rel;
                    OP_RPUSHPC: begin rs_op = SK_PUSH; rs_din = pc_rel; end
                    OP_RPOPPC:  begin rs_op = SK_POP;  cd.pc = rs_tos; end
                    OP_POPPC:   begin ds_op = SK_POP;  cd.pc = ds_tos; end
                    OP_PUSHS:   begin ds_op = SK_PUSH; ds_din = {{(DW-FW){1'b0}}, cq.flg}; end
                    OP_POPS:    begin ds_op = SK_POP;  cd.flg = ds_tos[FW-1:0]; end
                    OP_RPUSHS:  begin rs_op = SK_PUSH; rs_din = {{(DW-FW){1'b0}}, cq.flg}; end
                    OP_RPOPS:   begin rs_op = SK_POP;  cd.flg = rs_tos[FW-1:0]; end
                    OP_TOR:     begin rs_op = SK_PUSH; rs_din = ds_tos; ds_op = SK_POP; end
                    OP_FROMR:   begin rs_op = SK_POP;  ds_op = SK_PUSH; ds_din = rs_tos; end
                    default: ;
                endcase
            end
            S_LOADW: begin
                ds_op  = SK_PUSH;
                ds_din = {8'h00, mem_rdata};
                cd.st  = after_exec;
            end
            S_POPA: begin
                cd.a  = ds_tos;
                ds_op = SK_POP;
                cd.st = S_FETCH;
            end
            S_HALT: ;
            default: cd.st = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cq <= '{st: S_FETCH, default: '0};
        else        cq <= cd;
    end

    assign mem_addr    = bus_addr;
    assign mem_we      = bus_we;
    assign mem_wdata   = ds_tos[7:0];
    assign at_boundary = (cq.st == S_FETCH);
    assign halted      = (cq.st == S_HALT);
    assign dbg_pc      = cq.pc;
    assign dbg_a       = cq.a;
    assign dbg_flags   = cq.flg;
    assign dbg_tos     = ds_tos;
    assign dbg_nos     = ds_nos;
    assign dbg_rtos    = rs_tos;
    assign dbg_rnos    = rs_nos;

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.st == S_FETCH) |=> (cq.pc == $past(cq.pc) + 16'd1)); // R2
    AST_STORE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ds_tos == $past(ds_nos))); // R4
    AST_RET_FROM_RSTACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.st == S_EXEC && op7 == OP_RPOPPC) |=> (cq.pc == $past(rs_tos))); // R9
    AST_POPA_TAKES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cq.st == S_POPA) |=> (cq.a == $past(ds_tos))); // R12
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we)); // R14

endmodule

// File: tb/sim_stk_core.sv
`timescale 1ns/1ps
module sim_stk_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        at_boundary, halted;
    logic [15:0] dbg_pc, dbg_a, dbg_tos, dbg_nos, dbg_rtos, dbg_rnos;
    logic [1:0]  dbg_flags;

    always #2 clk = ~clk;

    stk_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .at_boundary(at_boundary),
        .halted(halted), .dbg_pc(dbg_pc), .dbg_a(dbg_a), .dbg_flags(dbg_flags),
        .dbg_tos(dbg_tos), .dbg_nos(dbg_nos), .dbg_rtos(dbg_rtos), .dbg_rnos(dbg_rnos));

    logic [7:0] ram [4096];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[11:0]];
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference state
    logic [7:0]  mmem [4096];
    logic [15:0] m_pc, m_a, m_tos, m_rtos;
    logic [15:0] m_ds [16];
    logic [15:0] m_rs [16];
    int          m_dsp, m_rsp;
    logic [1:0]  m_flg;
    bit          m_halt;
    bit          ring_tags;

    task automatic dpush(input logic [15:0] v);
        m_dsp = (m_dsp + 1) % 16; m_ds[m_dsp] = m_tos; m_tos = v;
    endtask
    task automatic dpop(output logic [15:0] v);
        v = m_tos; m_tos = m_ds[m_dsp]; m_dsp = (m_dsp + 15) % 16;
    endtask
    task automatic rpush(input logic [15:0] v);
        m_rsp = (m_rsp + 1) % 16; m_rs[m_rsp] = m_rtos; m_rtos = v;
    endtask
    task automatic rpop(output logic [15:0] v);
        v = m_rtos; m_rtos = m_rs[m_rsp]; m_rsp = (m_rsp + 15) % 16;
    endtask

    task automatic model_step(output int cyc, output string req);
        logic [7:0]  ir;
        logic [6:0]  op;
        logic [15:0] imm, rel, t;
        logic [16:0] s;
        int nb;
        ir = mmem[m_pc[11:0]]; m_pc = m_pc + 16'd1; op = ir[6:0];
        case (op)
            7'h01, 7'h0B, 7'h0C, 7'h0D, 7'h0E, 7'h0F, 7'h10: nb = 1;
            7'h02, 7'h0A: nb = 2;
            default: nb = 0;
        endcase
        imm = '0;
        for (int k = 0; k < nb; k++) begin
            imm = imm | (16'(mmem[m_pc[11:0]]) << (8 * k));
            m_pc = m_pc + 16'd1;
        end
        rel = m_pc + {{8{imm[7]}}, imm[7:0]};
        cyc = 3 + nb;
        req = "R2";
        case (op)
            7'h00: begin m_halt = 1'b1; req = "R14"; end
            7'h01: begin dpush({8'h00, imm[7:0]}); req = ring_tags ? "R13" : "R3"; end
            7'h02: begin dpush(imm); req = "R3"; end
            7'h03: begin dpush({8'h00, mmem[m_a[11:0]]}); cyc++; req = "R4"; end
            7'h04: begin mmem[m_a[11:0]] = m_tos[7:0]; dpop(t); req = "R4"; end
            7'h05: begin dpush(m_tos); req = "R5"; end
            7'h06: begin dpush(m_ds[m_dsp]); req = "R5"; end
            7'h07: begin dpop(t); req = ring_tags ? "R13" : "R5"; end
            7'h08: begin
                s = {1'b0, m_ds[m_dsp]} + {1'b0, m_tos};
                dpop(t); m_tos = s[15:0];
                m_flg = {s[16], s[15:0] == 16'd0}; req = "R6";
            end
            7'h09: begin
                s = {1'b0, m_tos} - 17'd1; m_tos = s[15:0];
                m_flg = {s[16], s[15:0] == 16'd0}; req = "R6";
            end
            7'h0A: begin m_pc = imm; req = "R8"; end
            7'h0B: begin m_pc = rel; req = "R8"; end
            7'h0C: begin if (m_flg[0])  m_pc = rel; req = "R7"; end
            7'h0D: begin if (!m_flg[0]) m_pc = rel; req = "R7"; end
            7'h0E: begin if (m_flg[1])  m_pc = rel; req = "R7"; end
            7'h0F: begin if (!m_flg[1]) m_pc = rel; req = "R7"; end
            7'h10: begin rpush(rel); req = "R9"; end
            7'h11: begin rpop(t); m_pc = t; req = "R9"; end
            7'h12: begin dpop(t); m_pc = t; req = "R8"; end
            7'h13: begin dpush({14'b0, m_flg}); req = "R10"; end
            7'h14: begin dpop(t); m_flg = t[1:0]; req = "R10"; end
            7'h15: begin rpush({14'b0, m_flg}); req = "R10"; end
            7'h16: begin rpop(t); m_flg = t[1:0]; req = "R10"; end
            7'h17: begin rpush(m_tos); dpop(t); req = "R11"; end
            7'h18: begin rpop(t); dpush(t); req = "R11"; end
            default: ;
        endcase
        if (ir[7] && op != 7'h00) begin
            m_a = m_tos; dpop(t); cyc++; req = "R12";
        end
    endtask

    task automatic compare_state(input string req);
        chk(req, "pc",    int'(dbg_pc),    int'(m_pc));
        chk(req, "a",     int'(dbg_a),     int'(m_a));
        chk(req, "flags", int'(dbg_flags), int'(m_flg));
        chk(req, "tos",   int'(dbg_tos),   int'(m_tos));
        chk(req, "nos",   int'(dbg_nos),   int'(m_ds[m_dsp]));
        chk(req, "rtos",  int'(dbg_rtos),  int'(m_rtos));
        chk(req, "rnos",  int'(dbg_rnos),  int'(m_rs[m_rsp]));
    endtask

    task automatic run_prog(input logic [7:0] img [], input int base);
        int since, exp_cyc, guard, bad;
        string req;
        bit first;
        rst_n = 1'b0;
        for (int i = 0; i < 4096; i++) begin ram[i] = 8'h00; mmem[i] = 8'h00; end
        for (int i = 0; i < img.size(); i++) begin
            ram[(base + i) % 4096] = img[i]; mmem[(base + i) % 4096] = img[i];
        end
        m_pc = '0; m_a = '0; m_tos = '0; m_rtos = '0; m_flg = '0;
        m_dsp = 0; m_rsp = 0; m_halt = 1'b0;
        for (int i = 0; i < 16; i++) begin m_ds[i] = '0; m_rs[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        since = 0; exp_cyc = 0; guard = 0; first = 1'b1; req = "R1";
        forever begin
            if (halted) begin
                chk(req, "halt timing", since, exp_cyc);
                chk("R14", "model halted", int'(m_halt), 1);
                break;
            end
            if (at_boundary) begin
                if (!first) chk(req, "cycles", since, exp_cyc);
                compare_state(req);
                if (m_halt) chk("R14", "boundary after halt", 1, 0);
                first = 1'b0;
                since = 0;
                model_step(exp_cyc, req);
            end
            @(negedge clk);
            since++; guard++;
            if (guard > 3000) begin
                chk("R2", "watchdog", guard, 0);
                break;
            end
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R14", "stays halted", int'(halted), 1);
            chk("R14", "no write when halted", int'(mem_we), 0);
        end
        bad = 0;
        for (int i = 0; i < 4096; i++) if (ram[i] !== mmem[i]) bad++;
        chk("R4", "memory image mismatches", bad, 0);
    endtask

    logic [7:0] p1 [];
    logic [7:0] p2 [];
    logic [7:0] p3 [];
    logic [7:0] p3s [];

    initial begin
        // immediates, memory through A, shuffles, arithmetic and flags
        p1 = '{8'h82, 8'h00, 8'h02, 8'h01, 8'hAB, 8'h04, 8'h03, 8'h01, 8'hFF,
               8'h08, 8'h05, 8'h06, 8'h07, 8'h02, 8'h55, 8'hFE, 8'h08,
               8'h02, 8'h01, 8'h00, 8'h08, 8'h09, 8'h88, 8'h83, 8'h00};
        ring_tags = 1'b0;
        run_prog(p1, 0);

        // count-down loop with stores, all four branch conditions
        p2 = '{8'h0A, 8'h40, 8'h00};
        run_prog(p2, 0);
        p2 = '{8'h0A, 8'h40, 8'h00};
        begin
            logic [7:0] body [];
            body = '{8'h01, 8'h03, 8'h85, 8'h05, 8'h04, 8'h09, 8'h0F, 8'hFA,
                     8'h0C, 8'h01, 8'h0D, 8'h01, 8'h00, 8'h0E, 8'h01, 8'h00,
                     8'h83, 8'h01, 8'h01, 8'h09, 8'h0C, 8'h01, 8'h00, 8'h00};
            p2 = new[8'h40 + body.size()](p2);
            for (int i = 3; i < 8'h40; i++) p2[i] = 8'h00;
            for (int i = 0; i < body.size(); i++) p2[8'h40 + i] = body[i];
        end
        run_prog(p2, 0);

        // call/return, relative skip, flags via both stacks, moves, computed jump
        p3 = new[8'h84];
        for (int i = 0; i < p3.size(); i++) p3[i] = 8'h00;
        p3s = '{8'h10, 8'h03, 8'h0A, 8'h80, 8'h00, 8'h0B, 8'h01, 8'h00,
                8'h13, 8'h15, 8'h14, 8'h16, 8'h17, 8'h18, 8'h7F,
                8'h02, 8'h13, 8'h00, 8'h12};
        for (int i = 0; i < p3s.size(); i++) p3[i] = p3s[i];
        for (int k = 0; k < 18; k++) begin
            p3[8'h13 + 2 * k]     = 8'h01;
            p3[8'h13 + 2 * k + 1] = 8'(8'h30 + k);
        end
        for (int k = 0; k < 17; k++) p3[8'h37 + k] = 8'h07;
        p3[8'h48] = 8'h00;
        p3[8'h80] = 8'h01; p3[8'h81] = 8'h00; p3[8'h82] = 8'h09; p3[8'h83] = 8'h11;
        ring_tags = 1'b1;
        run_prog(p3, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule